// File: doc/BRIEF.md
# Big-Endian Byte-Lane Load/Store Unit

This block connects a 32-bit processor core to a byte-addressed data memory that is one 32-bit word wide. On each request it forms the effective address from a base register and a signed 16-bit displacement. It then presents the memory with the word-aligned address, a 4-bit lane enable mask and write data that has been steered into the addressed lanes. Each lane carries one 8-bit byte.

Lanes follow big-endian order: the byte at the lowest address of a word sits in bits 31:24. When a load's data word comes back one cycle later, the unit picks out the addressed byte or halfword. It widens the result to 32 bits, with sign extension or with zero fill as the request asks. A request that breaks the alignment rule for its size is flagged. Such a request drives no lanes and starts no memory access.

Top module: `be_lsu`

## Requirements
- R1: The effective address is `base` plus `offset` sign-extended to 32 bits. `mem_addr` is that address with bits 1:0 forced to zero.
- R2: A byte access at offset k = address bits 1:0 enables only lane bit (3-k) of `mem_be`. Bit 3 covers data bits 31:24 and bit 0 covers bits 7:0.
- R3: A halfword access at offset 0 enables lanes 1100. At offset 2 it enables lanes 0011. A word access enables 1111. Size codes: 00 byte, 01 halfword, 10 word, 11 reserved.
- R4: On a store, every enabled lane carries the low byte of `wdata_reg` (byte store) or the matching half of the low halfword of `wdata_reg` (halfword store). A word store carries `wdata_reg` unchanged.
- R5: A halfword with address bit 0 set, a word with nonzero address bits 1:0, or size code 11 raises `misalign` and leaves `mem_be` zero, `mem_we` low and `mem_re` low.
- R6: An aligned load asserts `mem_re` in its request cycle. `load_valid` rises in the next cycle. The lane is chosen with the offset and size captured on the request cycle, so a new request in the same cycle does not disturb it.
- R7: A load with `req_signed`=1 copies bit 7 (byte) or bit 15 (halfword) of the picked value into all upper bits of `load_data`.
- R8: A load with `req_signed`=0 fills the upper 24 (byte) or 16 (halfword) bits of `load_data` with zeros.
- R9: A word load returns `rdata_mem` unchanged. A byte at offset k comes from bits 31-8k down to 24-8k. A halfword at offset 0 comes from bits 31:16 and one at offset 2 from bits 15:0.
- R10: After reset `load_valid` is low. With `req_valid` low, `mem_be` is zero and `mem_we`, `mem_re` and `misalign` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_signed | input | 1 | Load result is sign-extended when 1 |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| wdata_reg | input | 32 | Source register for stores |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Lane enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_we | output | 1 | Aligned store accepted |
| mem_re | output | 1 | Aligned load accepted |
| misalign | output | 1 | Request breaks its alignment rule |
| rdata_mem | input | 32 | Memory word, one cycle after `mem_re` |
| load_valid | output | 1 | `load_data` is valid |
| load_data | output | 32 | Extended load result |

## Verification
Random requests cover every size code and every byte offset, with negative and positive displacements. This separates the lane order from a little-endian mirror and the sign-extension path from the zero-fill path. A known big-endian word is stored and then read back as bytes, halfwords and the whole word, which pins each lane to a literal value. Byte values with bit 7 set expose a wrong extension choice. Back-to-back loads at different offsets show whether extraction uses the captured offset or the live one. Misaligned and reserved-size requests must leave the memory unchanged.

// File: rtl/be_lsu.sv
module be_lsu #(
  parameter int AW = 32,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_store,
  input  logic [1:0]    req_size,
  input  logic          req_signed,
  input  logic [AW-1:0] base,
  input  logic [OW-1:0] offset,
  input  logic [31:0]   wdata_reg,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic          misalign,
  input  logic [31:0]   rdata_mem,
  output logic          load_valid,
  output logic [31:0]   load_data
);
  localparam int XW = AW - OW;

  logic [AW-1:0] ea;
  logic [1:0]    k;
  logic [3:0]    lanes;
  logic          bad, ok;

  assign ea       = base + {{XW{offset[OW-1]}}, offset};
  assign k        = ea[1:0];
  assign mem_addr = {ea[AW-1:2], 2'b00};

  always_comb begin
    case (req_size)
      2'b00:   lanes = 4'b1000 >> k;
      2'b01:   lanes = k[1] ? 4'b0011 : 4'b1100;
      2'b10:   lanes = 4'b1111;
      default: lanes = 4'b0000;
    endcase
  end

  assign bad      = (req_size == 2'b11) || (req_size == 2'b01 && k[0]) || (req_size == 2'b10 && k != 2'b00);
  assign ok       = req_valid && !bad;
  assign misalign = req_valid && bad;
  assign mem_be   = ok ? lanes : 4'b0000;
  assign mem_we   = ok && req_store;
  assign mem_re   = ok && !req_store;

  always_comb begin
    case (req_size)
      2'b00:   mem_wdata = {4{wdata_reg[7:0]}};
      2'b01:   mem_wdata = {2{wdata_reg[15:0]}};
      default: mem_wdata = wdata_reg;
    endcase
  end

  logic [1:0] ld_k, ld_size;
  logic       ld_sgn, ld_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_v    <= 1'b0;
      ld_k    <= 2'b00;
      ld_size <= 2'b00;
      ld_sgn  <= 1'b0;
    end else begin
      ld_v <= mem_re;
      if (mem_re) begin
        ld_k    <= k;
        ld_size <= req_size;
        ld_sgn  <= req_signed;
      end
    end
  end

  logic [31:0] shifted;
  logic [7:0]  pb;
  logic [15:0] ph;

  assign shifted = rdata_mem >> {~ld_k, 3'b000};
  assign pb      = shifted[7:0];
  assign ph      = ld_k[1] ? rdata_mem[15:0] : rdata_mem[31:16];

  always_comb begin
    case (ld_size)
      2'b00:   load_data = {{24{ld_sgn & pb[7]}}, pb};
      2'b01:   load_data = {{16{ld_sgn & ph[15]}}, ph};
      default: load_data = rdata_mem;
    endcase
  end

  assign load_valid = ld_v;
endmodule

module be_lsu_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_store,
  input logic [1:0]  req_size,
  input logic        req_signed,
  input logic [31:0] wdata_reg,
  input logic [3:0]  mem_be,
  input logic [31:0] mem_wdata,
  input logic        mem_we,
  input logic        mem_re,
  input logic        misalign,
  input logic        load_valid,
  input logic [31:0] load_data
);
  a_r2_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'b00) |-> $countones(mem_be) == 1);

  a_r4_byte_lane_data: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && req_size == 2'b00 && mem_be[3]) |-> mem_wdata[31:24] == wdata_reg[7:0]);

  a_r5_misalign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (mem_be == 4'b0000 && !mem_we && !mem_re));

  a_r6_load_follows: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> load_valid);

  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_re |=> !load_valid);

  a_r7_sign_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && $past(req_size) == 2'b00 && $past(req_signed)) |-> load_data[31:8] == {24{load_data[7]}});

  a_r8_zero_half: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && $past(req_size) == 2'b01 && !$past(req_signed)) |-> load_data[31:16] == 16'h0000);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (mem_be == 4'b0000 && !mem_we && !mem_re && !misalign));
endmodule

bind be_lsu be_lsu_checks u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
  .req_size(req_size), .req_signed(req_signed), .wdata_reg(wdata_reg),
  .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
  .misalign(misalign), .load_valid(load_valid), .load_data(load_data)
);

// File: tb/test_be_lsu.sv
`timescale 1ns/1ps
module test_be_lsu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_signed = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [31:0] base = '0, wdata_reg = '0;
  logic [15:0] offset = '0;
  logic [31:0] mem_addr, mem_wdata, rdata_mem, load_data;
  logic [3:0]  mem_be;
  logic        mem_we, mem_re, misalign, load_valid;

  int tests = 0, fails = 0;
  logic [7:0]  bm [64];
  logic [31:0] rdq = '0;

  always #2 clk = ~clk;

  be_lsu i_be_lsu (.*);

  assign rdata_mem = rdq;

  always @(posedge clk) begin
    if (mem_we)
      for (int j = 0; j < 4; j++)
        if (mem_be[3-j]) bm[{mem_addr[5:2], 2'(j)}] <= mem_wdata[31-8*j -: 8];
    if (mem_re)
      rdq <= {bm[{mem_addr[5:2], 2'd0}], bm[{mem_addr[5:2], 2'd1}],
              bm[{mem_addr[5:2], 2'd2}], bm[{mem_addr[5:2], 2'd3}]};
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] k);
    case (sz)
      2'b00: return 4'b0001 << (3 - k);
      2'b01: return (k == 2'd0) ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic exp_bad(input logic [1:0] sz, input logic [1:0] k);
    return sz == 2'b11 || (sz == 2'b01 && k[0]) || (sz == 2'b10 && k != 2'd0);
  endfunction

  function automatic logic [31:0] exp_load(input logic [5:0] a, input logic [1:0] sz, input logic sg);
    logic [7:0] b; logic [15:0] h;
    b = bm[a];
    h = {bm[a], bm[a + 6'd1]};
    case (sz)
      2'b00: return sg ? {{24{b[7]}}, b} : {24'h0, b};
      2'b01: return sg ? {{16{h[15]}}, h} : {16'h0, h};
      default: return {bm[a], bm[a + 6'd1], bm[a + 6'd2], bm[a + 6'd3]};
    endcase
  endfunction

  task automatic op(input logic st, input logic [1:0] sz, input logic sg,
                    input logic [31:0] b, input logic [15:0] o, input logic [31:0] wd);
    logic [31:0] ea, lexp;
    logic [1:0]  k;
    logic        bad;
    logic [3:0]  be;
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_size = sz; req_signed = sg;
    base = b; offset = o; wdata_reg = wd;
    ea  = b + {{16{o[15]}}, o};
    k   = ea[1:0];
    bad = exp_bad(sz, k);
    be  = bad ? 4'b0000 : exp_be(sz, k);
    #1;
    chk("R1 mem_addr", mem_addr, {ea[31:2], 2'b00});
    chk("R2/R3 mem_be", {28'h0, mem_be}, {28'h0, be});
    chk("R5 misalign", {31'h0, misalign}, {31'h0, bad});
    chk("R5 we/re", {30'h0, mem_we, mem_re}, {30'h0, st && !bad, !st && !bad});
    if (st && !bad)
      for (int j = 0; j < 4; j++)
        if (be[3-j])
          chk("R4 lane data", {24'h0, mem_wdata[31-8*j -: 8]},
              {24'h0, (sz == 2'b00) ? wd[7:0] : (sz == 2'b01) ? (j[0] ? wd[7:0] : wd[15:8]) : wd[31-8*j -: 8]});
    lexp = exp_load(ea[5:0], sz, sg);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk("R6 load_valid", {31'h0, load_valid}, {31'h0, !st && !bad});
    if (!st && !bad) chk("R7/R8/R9 load_data", load_data, lexp);
  endtask

  task automatic ld_expect(input logic [1:0] sz, input logic sg, input logic [15:0] o,
                           input logic [31:0] exp, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_store = 1'b0; req_size = sz; req_signed = sg; base = 32'h0; offset = o;
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(req, load_data, exp);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'hC0DE5EED));
    for (int i = 0; i < 64; i++) bm[i] = 8'(i * 37 + 5);
    #1;
    chk("R10 reset load_valid", {31'h0, load_valid}, 32'h0);
    chk("R10 idle be", {28'h0, mem_be}, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    op(1'b1, 2'b10, 1'b0, 32'h0, 16'h0, 32'h11223344);
    ld_expect(2'b00, 1'b0, 16'd0, 32'h00000011, "R9 byte offset 0 is bits 31:24");
    ld_expect(2'b00, 1'b0, 16'd3, 32'h00000044, "R9 byte offset 3 is bits 7:0");
    ld_expect(2'b01, 1'b0, 16'd2, 32'h00003344, "R9 halfword offset 2");
    ld_expect(2'b10, 1'b0, 16'd0, 32'h11223344, "R9 word");
    op(1'b1, 2'b00, 1'b0, 32'h0, 16'd1, 32'hDEADBEF0);
    ld_expect(2'b10, 1'b0, 16'd0, 32'h11F03344, "R2 byte store lane");
    ld_expect(2'b00, 1'b1, 16'd1, 32'hFFFFFFF0, "R7 signed byte");
    ld_expect(2'b00, 1'b0, 16'd1, 32'h000000F0, "R8 unsigned byte");
    op(1'b1, 2'b01, 1'b0, 32'h0, 16'd2, 32'h0000A55A);
    ld_expect(2'b01, 1'b1, 16'd2, 32'hFFFFA55A, "R7 signed half");
    ld_expect(2'b01, 1'b0, 16'd0, 32'h000011F0, "R3 half offset 0 untouched by offset-2 store");
    op(1'b1, 2'b10, 1'b0, 32'h0, 16'd2, 32'hFFFFFFFF);
    ld_expect(2'b10, 1'b0, 16'd0, 32'h11F0A55A, "R5 misaligned store writes nothing");
    op(1'b0, 2'b11, 1'b0, 32'h8, 16'h0, 32'h0);
    op(1'b0, 2'b00, 1'b0, 32'h20, 16'hFFE1, 32'h0);

    @(negedge clk);
    req_valid = 1'b1; req_store = 1'b0; req_size = 2'b00; req_signed = 1'b0; base = 32'h0; offset = 16'd0;
    @(negedge clk);
    offset = 16'd3;
    #1;
    chk("R6 captured offset in back-to-back", load_data, 32'h00000011);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk("R6 second back-to-back load", load_data, 32'h0000005A);

    for (int n = 0; n < 400; n++) begin
      logic [1:0]  sz;
      logic [31:0] b;
      logic [15:0] o;
      sz = 2'($urandom % 4);
      b  = 32'($urandom % 256) + 32'h100;
      o  = 16'(32'($urandom % 128) - 32'd64);
      op(1'($urandom % 2), sz, 1'($urandom % 2), b, o, $urandom);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule